// File: doc/BRIEF.md
# Nanosecond Clock and Per-Thread Deadline Unit

This block keeps a free-running 64-bit nanosecond count, starting at zero on reset. It serves the timing operations of a multithreaded core. The pipeline presents at most one command per cycle, tagged with the issuing thread. The command can read the low or high word of the time, set a delay-until target, arm an expiry exception at an absolute time, or disarm that exception.

Each thread owns a delay target, an exception target and a capture register for the high word. Two comparators per thread check the targets against the current time on every cycle. The pipeline uses the per-thread pending flag to replay a delay instruction until its target has been reached. The expiry pulse goes to exception handling. The wake pulse goes to the thread scheduler, so that a sleeping thread can be resumed by a timer event without polling.

Top module: `ns_deadline_unit`

## Requirements
- R1: `time_now` is zero after reset. It grows by NS_PER_CYCLE on every clock edge while reset is released.
- R2: A read-low command (`cmd_op` = 1) returns `time_now[31:0]` on `rd_data` in the same cycle. At that edge it also copies `time_now[63:32]` into the issuing thread's capture register.
- R3: A read-high command (`cmd_op` = 2) returns the issuing thread's capture register, not the live high word. Each thread's capture register is changed only by that thread's own read-low.
- R4: On a delay command (`cmd_op` = 3) the target `{cmd_hi,cmd_lo}` is stored. From the next cycle, `delay_pending[t]` is 1 exactly while `time_now` is below the target. A new delay command replaces the old target.
- R5: In the first cycle that an active delay sees `time_now` >= its target, the delay ends. `wake_req[t]` is 1 for one cycle in the following cycle.
- R6: An arm command (`cmd_op` = 4) stores `{cmd_hi,cmd_lo}` as the expiry target. In the first cycle where the thread is armed and `time_now` is strictly greater than the target, the thread disarms. `exc_fire[t]` and `wake_req[t]` are then 1 for exactly one cycle, in the following cycle. Equality does not fire.
- R7: Arming a thread that is already armed replaces its target. The old target can no longer fire.
- R8: A disarm command (`cmd_op` = 5) clears the thread's armed state. A disarm issued in the cycle that would have fired gives no `exc_fire` pulse.
- R9: Commands with `cmd_valid` = 0, codes 0, 6 and 7, or a thread number of N_THREADS or more change no state. For all of these, `rd_data` is 0.
- R10: While reset is asserted, every output is 0 and all armed, pending and captured state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Command code (see R2 to R9) |
| cmd_tid | input | TID_W | Issuing thread |
| cmd_hi | input | WORD_W | Upper word of a target time |
| cmd_lo | input | WORD_W | Lower word of a target time |
| rd_data | output | WORD_W | Result of a time read |
| time_now | output | 2*WORD_W | Current nanosecond count |
| delay_pending | output | N_THREADS | Delay not yet reached, per thread |
| exc_fire | output | N_THREADS | One-cycle expiry pulse, per thread |
| wake_req | output | N_THREADS | One-cycle wake pulse to the scheduler, per thread |

## Verification
Some properties are checked on every cycle:
- the time advances by a fixed step;
- a read-low captures the high word;
- a fire only follows an armed state and never lasts two cycles;
- a disarm always blocks the fire in the following cycle;
- every wake has an armed or delayed thread behind it.

Other behaviour is shown only by the bench scenarios, using a large time step so that the high word moves every few cycles:
- the exact cycle in which a pulse appears;
- the strict versus non-strict comparison at equality;
- target replacement;
- per-thread isolation of the capture registers;
- that an interrupted read pair still returns the captured high word.

// File: rtl/ns_timer_pkg.sv
package ns_timer_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_RDLO   = 3'd1,
      OP_RDHI   = 3'd2,
      OP_DELAY  = 3'd3,
      OP_ARM    = 3'd4,
      OP_DISARM = 3'd5
   } tmr_op_e;
endpackage

// File: rtl/ns_time_base.sv
module ns_time_base #(
   parameter int unsigned TIME_W       = 64,
   parameter int unsigned NS_PER_CYCLE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] now
);
   localparam logic [TIME_W-1:0] STEP = TIME_W'(NS_PER_CYCLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now <= '0;
      else        now <= now + STEP;
   end

   // R1: the count moves by exactly one step per edge
   a_r1_time_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> now == $past(now) + STEP);
endmodule

// File: rtl/ns_cmp.sv
module ns_cmp #(
   parameter int unsigned W     = 64,
   parameter bit          SPLIT = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic         ge,
   output logic         gt
);
   localparam int unsigned HW = W / 2;

   generate
      if (SPLIT) begin : g_split
         logic hi_gt, hi_eq, lo_gt, lo_eq;
         assign hi_gt = a[W-1:HW] > b[W-1:HW];
         assign hi_eq = a[W-1:HW] == b[W-1:HW];
         assign lo_gt = a[HW-1:0] > b[HW-1:0];
         assign lo_eq = a[HW-1:0] == b[HW-1:0];
         assign gt = hi_gt | (hi_eq & lo_gt);
         assign ge = hi_gt | (hi_eq & (lo_gt | lo_eq));
      end else begin : g_flat
         assign gt = a > b;
         assign ge = a >= b;
      end
   endgenerate
endmodule

// File: rtl/ns_thread_timer.sv
module ns_thread_timer
   import ns_timer_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter bit          SPLIT_CMP = 1'b1,
   localparam int unsigned TIME_W   = 2 * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  tmr_op_e           op,
   input  logic [TIME_W-1:0] tgt,
   input  logic [TIME_W-1:0] now,
   output logic [WORD_W-1:0] hcap_o,
   output logic              pending_o,
   output logic              fire_o,
   output logic              wake_o
);
   logic              dly_act, exc_arm;
   logic [TIME_W-1:0] dly_tgt, exc_tgt;
   logic              d_ge, d_gt_unused, e_ge_unused, e_gt;
   logic              is_arm, is_dis, is_dly, is_rdlo;
   logic              fire_n, done_n;

   ns_cmp #(.W(TIME_W), .SPLIT(SPLIT_CMP)) u_dcmp (
      .a(now), .b(dly_tgt), .ge(d_ge), .gt(d_gt_unused));
   ns_cmp #(.W(TIME_W), .SPLIT(SPLIT_CMP)) u_ecmp (
      .a(now), .b(exc_tgt), .ge(e_ge_unused), .gt(e_gt));

   always_comb begin
      is_arm  = sel && (op == OP_ARM);
      is_dis  = sel && (op == OP_DISARM);
      is_dly  = sel && (op == OP_DELAY);
      is_rdlo = sel && (op == OP_RDLO);
      fire_n  = exc_arm && e_gt && !is_arm && !is_dis;
      done_n  = dly_act && d_ge && !is_dly;
   end

   assign pending_o = dly_act & ~d_ge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dly_act <= 1'b0;
         dly_tgt <= '0;
         exc_arm <= 1'b0;
         exc_tgt <= '0;
         hcap_o  <= '0;
         fire_o  <= 1'b0;
         wake_o  <= 1'b0;
      end else begin
         if (is_arm) begin
            exc_arm <= 1'b1;
            exc_tgt <= tgt;
         end else if (is_dis || fire_n) begin
            exc_arm <= 1'b0;
         end
         if (is_dly) begin
            dly_act <= 1'b1;
            dly_tgt <= tgt;
         end else if (done_n) begin
            dly_act <= 1'b0;
         end
         if (is_rdlo) hcap_o <= now[TIME_W-1:WORD_W];
         fire_o <= fire_n;
         wake_o <= fire_n | done_n;
      end
   end

   // R6: a fire needs an armed thread one cycle earlier
   a_r6_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(exc_arm));
   // R6: the expiry pulse is never longer than one cycle
   a_r6_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |=> !fire_o);
   // R8: a disarm suppresses the fire that follows it
   a_r8_disarm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      is_dis |=> !fire_o);
   // R5: every wake comes from an armed or delayed thread
   a_r5_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> ($past(exc_arm) || $past(dly_act)));
   // R2: read-low captures the high word it saw
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      is_rdlo |=> hcap_o == $past(now[TIME_W-1:WORD_W]));
endmodule

// File: rtl/ns_deadline_unit.sv
module ns_deadline_unit
   import ns_timer_pkg::*;
#(
   parameter int unsigned N_THREADS    = 4,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned NS_PER_CYCLE = 10,
   parameter bit          SPLIT_CMP    = 1'b1,
   localparam int unsigned TID_W  = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
   localparam int unsigned TIME_W = 2 * WORD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic [2:0]           cmd_op,
   input  logic [TID_W-1:0]     cmd_tid,
   input  logic [WORD_W-1:0]    cmd_hi,
   input  logic [WORD_W-1:0]    cmd_lo,
   output logic [WORD_W-1:0]    rd_data,
   output logic [TIME_W-1:0]    time_now,
   output logic [N_THREADS-1:0] delay_pending,
   output logic [N_THREADS-1:0] exc_fire,
   output logic [N_THREADS-1:0] wake_req
);
   initial begin : elab_chk
      assert (N_THREADS >= 1) else $error("N_THREADS must be at least 1");
      assert (WORD_W >= 8) else $error("WORD_W must be at least 8");
      assert (NS_PER_CYCLE >= 1) else $error("NS_PER_CYCLE must be nonzero");
   end

   tmr_op_e           op_e;
   logic [TIME_W-1:0] tgt;
   logic              tid_ok;
   logic [WORD_W-1:0] hcap [N_THREADS];

   assign op_e   = tmr_op_e'(cmd_op);
   assign tgt    = {cmd_hi, cmd_lo};
   assign tid_ok = 32'(cmd_tid) < N_THREADS;

   ns_time_base #(.TIME_W(TIME_W), .NS_PER_CYCLE(NS_PER_CYCLE)) u_tb (
      .clk(clk), .rst_n(rst_n), .now(time_now));

   generate
      for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
         logic sel;
         assign sel = cmd_valid && tid_ok && (32'(cmd_tid) == t);
         ns_thread_timer #(.WORD_W(WORD_W), .SPLIT_CMP(SPLIT_CMP)) u_thr (
            .clk(clk), .rst_n(rst_n), .sel(sel), .op(op_e), .tgt(tgt),
            .now(time_now), .hcap_o(hcap[t]), .pending_o(delay_pending[t]),
            .fire_o(exc_fire[t]), .wake_o(wake_req[t]));
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (cmd_valid && tid_ok) begin
         case (op_e)
            OP_RDLO: rd_data = time_now[WORD_W-1:0];
            OP_RDHI: rd_data = hcap[cmd_tid];
            default: rd_data = '0;
         endcase
      end
   end

   // R6: a thread with a fire pulse is not pending a fire on the next edge
   a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_fire != '0) |=> (($past(exc_fire) & exc_fire) == '0));
endmodule

// File: tb/ns_deadline_unit_test.sv
module ns_deadline_unit_test;
   localparam int unsigned NT   = 4;
   localparam int unsigned STEP = 32'h1000_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [1:0]  cmd_tid = '0;
   logic [31:0] cmd_hi = '0, cmd_lo = '0;
   logic [31:0] rd_data;
   logic [63:0] time_now;
   logic [NT-1:0] delay_pending, exc_fire, wake_req;

   int n_chk = 0, n_bad = 0;
   longint unsigned ecyc = 0;

   logic        m_arm [NT], m_dact [NT];
   logic [63:0] m_etgt [NT], m_dtgt [NT];
   logic [31:0] m_hcap [NT];

   ns_deadline_unit #(.N_THREADS(NT), .WORD_W(32), .NS_PER_CYCLE(STEP)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_tid(cmd_tid), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo), .rd_data(rd_data),
      .time_now(time_now), .delay_pending(delay_pending), .exc_fire(exc_fire),
      .wake_req(wake_req));

   always #5 clk = ~clk;
   always @(posedge clk) if (rst_n) ecyc <= ecyc + 1;

   function automatic logic [63:0] exp_now();
      return ecyc * 64'(STEP);
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // one command cycle, starting just after a falling edge
   task automatic step(logic v, logic [2:0] op, logic [1:0] tid, logic [63:0] tv);
      logic [63:0] n;
      logic [31:0] erd;
      logic [NT-1:0] epend, efire, ewake;
      n = exp_now();
      chk("R1 time", time_now, n);
      cmd_valid = v; cmd_op = op; cmd_tid = tid;
      cmd_hi = tv[63:32]; cmd_lo = tv[31:0];
      #1;
      erd = '0;
      if (v && op == 3'd1) erd = n[31:0];
      if (v && op == 3'd2) erd = m_hcap[tid];
      chk((v && op == 3'd2) ? "R3 rdhi" : "R2 R9 rd_data", 64'(rd_data), 64'(erd));
      for (int t = 0; t < NT; t++) epend[t] = m_dact[t] && (n < m_dtgt[t]);
      chk("R4 pending", 64'(delay_pending), 64'(epend));
      for (int t = 0; t < NT; t++) begin
         logic s, done;
         s = v && (tid == t);
         efire[t] = 1'b0; done = 1'b0;
         if (s && op == 3'd4) begin m_arm[t] = 1'b1; m_etgt[t] = tv; end
         else if (s && op == 3'd5) m_arm[t] = 1'b0;
         else if (m_arm[t] && n > m_etgt[t]) begin efire[t] = 1'b1; m_arm[t] = 1'b0; end
         if (s && op == 3'd3) begin m_dact[t] = 1'b1; m_dtgt[t] = tv; end
         else if (m_dact[t] && n >= m_dtgt[t]) begin done = 1'b1; m_dact[t] = 1'b0; end
         ewake[t] = efire[t] | done;
         if (s && op == 3'd1) m_hcap[t] = n[63:32];
      end
      @(posedge clk);
      @(negedge clk);
      chk("R6 R7 R8 exc_fire", 64'(exc_fire), 64'(efire));
      chk("R5 R6 wake_req", 64'(wake_req), 64'(ewake));
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) step(1'b0, 3'd0, 2'd0, 64'd0);
   endtask

   initial begin
      #(10 * 200000);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [63:0] n0;
      void'($urandom(32'd4711));
      for (int t = 0; t < NT; t++) begin
         m_arm[t] = 0; m_dact[t] = 0; m_etgt[t] = 0; m_dtgt[t] = 0; m_hcap[t] = 0;
      end
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 time", time_now, 64'd0);
      chk("R10 pending", 64'(delay_pending), 64'd0);
      chk("R10 fire", 64'(exc_fire), 64'd0);
      chk("R10 wake", 64'(wake_req), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      idle(2);

      // R2 R3: read pair interrupted by other work and a high-word roll
      n0 = exp_now();
      step(1'b1, 3'd1, 2'd0, 64'd0);
      idle(3);
      step(1'b1, 3'd1, 2'd1, 64'd0);
      idle(20);
      chk("R3 captured hi moved on", 64'(exp_now() > n0 + 64'(STEP) * 20), 64'd1);
      step(1'b1, 3'd2, 2'd0, 64'd0);
      step(1'b1, 3'd2, 2'd1, 64'd0);

      // R4 R5: delay with target exactly on a future time value
      step(1'b1, 3'd3, 2'd1, exp_now() + 64'(STEP) * 3);
      idle(5);

      // R6: arm with target equal to a future time, fire only after it passes
      step(1'b1, 3'd4, 2'd2, exp_now() + 64'(STEP) * 2);
      idle(5);

      // R8: disarm in the very cycle that would fire
      n0 = exp_now();
      step(1'b1, 3'd4, 2'd3, n0 + 64'(STEP));
      idle(1);
      step(1'b1, 3'd5, 2'd3, 64'd0);
      idle(3);

      // R7: re-arm replaces the target
      step(1'b1, 3'd4, 2'd0, exp_now() + 64'(STEP));
      step(1'b1, 3'd4, 2'd0, exp_now() + 64'(STEP) * 30);
      idle(35);

      // R9: invalid codes and invalid strobe leave state untouched
      step(1'b1, 3'd6, 2'd2, exp_now());
      step(1'b1, 3'd7, 2'd2, exp_now());
      step(1'b0, 3'd4, 2'd2, exp_now());
      step(1'b0, 3'd1, 2'd2, 64'd0);
      step(1'b1, 3'd2, 2'd2, 64'd0);
      idle(3);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [63:0] tv;
         logic v;
         v = ($urandom % 8) != 0;
         tv = exp_now() + 64'(($urandom % 24)) * 64'(STEP / 4) - 64'(STEP);
         if (($urandom % 6) == 0) tv = exp_now() + 64'(STEP) * 64'($urandom % 4);
         step(v, 3'($urandom % 8), 2'($urandom % NT), tv);
      end
      idle(30);

      summary();
      $finish;
   end
endmodule